// File: doc/BRIEF.md
# Vector register pair save/restore sequencer

This block moves one pair of vector registers between the vector register file and a save area in memory, one element at a time. A control unit hands it the contents of two general registers: an address register that points into the save area, and a control register that carries the starting element number in bits 31:16 and the even pair number in bits 15:0. The block checks these operands and decides from the pair's status bits whether the pair needs moving. It then runs one 64-bit memory beat per element, from the starting element to the last element of the section. It returns the updated register values and a two-bit condition code.

Three modes are supported. Plain save and restore move the pair when its in-use bit is set. Save-changed moves it only when its changed bit is set, and requires supervisor state. A skipped pair costs no memory traffic: the address simply jumps to the end of the pair's area. Because the element field is an input, an interrupted sequence can be resumed part way through a pair. The memory and the register file sit outside the block and are reached through request/acknowledge ports.

Top module: `vpair_xfer_seq`

## Requirements
- R1: A start with the element field (bits 31:16 of the control register) at or above SECT, with any bit of the pair field (bits 15:0) set under mask 0xFFF1, with an odd base register number, or with mode 2'b11 ends with spec_err=1. No memory or register-file request is made, gr_addr_out and gr_ctl_out equal the inputs, and cc=0.
- R2: A start is also a specification error when (address − 8×start element) is not a multiple of 4×SECT bytes.
- R3: Save-changed (mode 2'b01) with priv=0 ends with priv_err=1 and spec_err=0 even when a specification error is also present. It makes no transfer and leaves the register values unchanged.
- R4: Each element is one 64-bit doubleword. The even register's element occupies bits 63:32 and the odd register's element occupies bits 31:0, in both directions.
- R5: A transfer issues exactly one memory beat per element, for elements start..SECT−1, at addresses that begin at the given address and rise by 8. The memory port and the register-file port are never requested in the same cycle.
- R6: A skipped pair makes no memory or register-file request, and gr_addr_out = address + 8×(SECT − start element).
- R7: cc is 2'd2 (pair 14 moved), 2'd0 (pair 14 skipped), 2'd3 (any other pair moved) or 2'd1 (any other pair skipped).
- R8: On success gr_ctl_out equals the pair number plus 2 with bits 31:16 zero, and after a transfer gr_addr_out = address + 8×(SECT − start element).
- R9: A completed save-changed transfer pulses chg_clr with chg_pair equal to the pair index (pair number / 2) in the done cycle. A completed restore with priv=0 pulses chg_set the same way. No other case pulses either.
- R10: Save (2'b00) and restore (2'b10) test the pair's pair_inuse bit, and save-changed tests its pair_changed bit. Bit k of each vector belongs to pair number 2k.
- R11: busy rises the cycle after start and stays high through the single done cycle, and both are low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| mode | input | 2 | 00 save, 01 save-changed, 10 restore, 11 reserved |
| priv | input | 1 | 1 = supervisor state |
| base_gr | input | 4 | Number of the address general register |
| gr_addr_in | input | 32 | Save-area address register value |
| gr_ctl_in | input | 32 | Element (31:16) and pair number (15:0) |
| pair_inuse | input | 8 | In-use bit per pair |
| pair_changed | input | 8 | Changed bit per pair |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 2*ELEM_W | Memory write data |
| mem_rdata | input | 2*ELEM_W | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |
| vr_req | output | 1 | Register-file request, held until acknowledged |
| vr_we | output | 1 | 1 = register-file write |
| vr_pair | output | 3 | Pair index |
| vr_elem | output | $clog2(SECT) | Element number |
| vr_wd_hi | output | ELEM_W | Write data for the even register |
| vr_wd_lo | output | ELEM_W | Write data for the odd register |
| vr_rd_hi | input | ELEM_W | Read data of the even register |
| vr_rd_lo | input | ELEM_W | Read data of the odd register |
| vr_ack | input | 1 | Register-file acknowledge |
| chg_set | output | 1 | Set the changed bit of chg_pair |
| chg_clr | output | 1 | Clear the changed bit of chg_pair |
| chg_pair | output | 3 | Pair index for chg_set/chg_clr |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| spec_err | output | 1 | Specification error (valid with done) |
| priv_err | output | 1 | Privilege error (valid with done) |
| cc | output | 2 | Condition code (valid with done) |
| gr_addr_out | output | 32 | Updated address register |
| gr_ctl_out | output | 32 | Updated control register |

## Verification
The bench resumes transfers part way through a pair, on pair 14 and on lower pairs. A block that restarted from element 0 or mis-scaled the skip distance would write the wrong save-area words and return the wrong final address. Skips of pair 14 and of another pair separate the four condition codes. Swapping the transferred and last-pair meanings, or the halves of the doubleword, shows up directly in cc and in the memory and register contents. Each specification error cause is tried alone, and a privilege error is combined with a misalignment. A design with the wrong priority, or one that touches memory before its checks finish, reports the wrong flag, moves beats, or alters the register values. The changed-bit pulses are compared across supervisor and problem state, so a block that sets or clears them on the wrong mode or on a skip is caught.

// File: rtl/vpx_pkg.sv
package vpx_pkg;

  localparam int GR_W = 32;

  typedef enum logic [1:0] {
    MD_SAVE     = 2'b00,
    MD_SAVE_CHG = 2'b01,
    MD_RESTORE  = 2'b10,
    MD_RSVD     = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_STORE,
    ST_FIN
  } seq_state_e;

  // byte offset covering elements start..sect-1
  function automatic logic [GR_W-1:0] tail_bytes(input logic [15:0] start_elem,
                                                 input int unsigned sect);
    logic [GR_W-1:0] rem;
    rem = GR_W'(sect) - {16'h0, start_elem};
    return rem << 3;
  endfunction

  // address minus the offset of the start element must sit on a 4*sect byte boundary
  function automatic logic area_aligned(input logic [GR_W-1:0] addr,
                                        input logic [15:0] start_elem,
                                        input int unsigned sect);
    logic [GR_W-1:0] base;
    logic [GR_W-1:0] msk;
    base = addr - ({16'h0, start_elem} << 3);
    msk  = GR_W'(4 * sect) - 1;
    return (base & msk) == '0;
  endfunction

  // bit1: pair moved, bit0: not the final pair
  function automatic logic [1:0] cond_code(input logic [2:0] pair_idx, input logic moved);
    return {moved, (pair_idx != 3'd7)};
  endfunction

  function automatic logic [GR_W-1:0] next_ctl(input logic [2:0] pair_idx);
    logic [4:0] nxt;
    nxt = {1'b0, pair_idx, 1'b0} + 5'd2;
    return {{(GR_W-5){1'b0}}, nxt};
  endfunction

endpackage

// File: rtl/vpx_check.sv
module vpx_check
  import vpx_pkg::*;
#(
  parameter int SECT  = 16,
  parameter int NPAIR = 8
) (
  input  logic [1:0]      mode,
  input  logic            priv,
  input  logic [3:0]      base_gr,
  input  logic [GR_W-1:0] gr_addr_in,
  input  logic [GR_W-1:0] gr_ctl_in,
  input  logic [NPAIR-1:0] pair_inuse,
  input  logic [NPAIR-1:0] pair_changed,
  output logic            spec_err,
  output logic            priv_err,
  output logic            take,
  output logic [2:0]      pair_idx,
  output logic [15:0]     start_elem
);
  logic [15:0] pair_num;
  logic        bad_elem, bad_pair, bad_align, bad_base, bad_mode;

  assign start_elem = gr_ctl_in[31:16];
  assign pair_num   = gr_ctl_in[15:0];
  assign pair_idx   = pair_num[3:1];

  assign bad_elem  = start_elem >= 16'(SECT);
  assign bad_pair  = (pair_num & 16'hFFF1) != 16'h0;
  assign bad_align = !area_aligned(gr_addr_in, start_elem, SECT);
  assign bad_base  = base_gr[0];
  assign bad_mode  = (mode == MD_RSVD);

  assign priv_err = (mode == MD_SAVE_CHG) && !priv;
  assign spec_err = !priv_err && (bad_elem || bad_pair || bad_align || bad_base || bad_mode);

  always_comb begin
    if (mode == MD_SAVE_CHG) take = pair_changed[pair_idx];
    else                     take = pair_inuse[pair_idx];
  end
endmodule

// File: rtl/vpx_beat.sv
module vpx_beat
  import vpx_pkg::*;
#(
  parameter int SECT   = 16,
  parameter int ELEM_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [GR_W-1:0]     load_addr,
  input  logic [15:0]         load_elem,
  input  logic                adv,
  input  logic                cap_mem,
  input  logic [2*ELEM_W-1:0] mem_rdata,
  input  logic                cap_vr,
  input  logic [ELEM_W-1:0]   vr_hi,
  input  logic [ELEM_W-1:0]   vr_lo,
  output logic [GR_W-1:0]     addr_q,
  output logic [15:0]         elem_q,
  output logic [2*ELEM_W-1:0] data_q,
  output logic                last_elem
);
  assign last_elem = (elem_q == 16'(SECT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      elem_q <= '0;
    end else if (load) begin
      addr_q <= load_addr;
      elem_q <= load_elem;
    end else if (adv) begin
      addr_q <= addr_q + GR_W'(8);
      elem_q <= elem_q + 16'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (cap_vr)  data_q <= {vr_hi, vr_lo};
    else if (cap_mem) data_q <= mem_rdata;
  end
endmodule

// File: rtl/vpair_xfer_seq.sv
module vpair_xfer_seq
  import vpx_pkg::*;
#(
  parameter int SECT   = 16,
  parameter int ELEM_W = 32,
  localparam int EW    = $clog2(SECT),
  localparam int DW    = 2 * ELEM_W,
  localparam int NPAIR = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic             priv,
  input  logic [3:0]       base_gr,
  input  logic [31:0]      gr_addr_in,
  input  logic [31:0]      gr_ctl_in,
  input  logic [NPAIR-1:0] pair_inuse,
  input  logic [NPAIR-1:0] pair_changed,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_ack,
  output logic             vr_req,
  output logic             vr_we,
  output logic [2:0]       vr_pair,
  output logic [EW-1:0]    vr_elem,
  output logic [ELEM_W-1:0] vr_wd_hi,
  output logic [ELEM_W-1:0] vr_wd_lo,
  input  logic [ELEM_W-1:0] vr_rd_hi,
  input  logic [ELEM_W-1:0] vr_rd_lo,
  input  logic             vr_ack,
  output logic             chg_set,
  output logic             chg_clr,
  output logic [2:0]       chg_pair,
  output logic             busy,
  output logic             done,
  output logic             spec_err,
  output logic             priv_err,
  output logic [1:0]       cc,
  output logic [31:0]      gr_addr_out,
  output logic [31:0]      gr_ctl_out
);
  seq_state_e state;
  xfer_mode_e mode_q;
  logic       priv_q, moved_q;
  logic [2:0] pair_q;

  logic        c_spec, c_priv, c_take;
  logic [2:0]  c_pair;
  logic [15:0] c_elem;

  logic [31:0] addr_q;
  logic [15:0] elem_q;
  logic [DW-1:0] data_q;
  logic        last_elem;

  logic        is_rst, accept, src_ack, dst_ack, beat_adv, cap_vr, cap_mem;

  vpx_check #(.SECT(SECT), .NPAIR(NPAIR)) u_check (
    .mode(mode), .priv(priv), .base_gr(base_gr),
    .gr_addr_in(gr_addr_in), .gr_ctl_in(gr_ctl_in),
    .pair_inuse(pair_inuse), .pair_changed(pair_changed),
    .spec_err(c_spec), .priv_err(c_priv), .take(c_take),
    .pair_idx(c_pair), .start_elem(c_elem)
  );

  assign accept  = (state == ST_IDLE) && start;
  assign is_rst  = (mode_q == MD_RESTORE);
  // restore reads memory and writes the register file; the save modes do the reverse
  assign src_ack = is_rst ? mem_ack : vr_ack;
  assign dst_ack = is_rst ? vr_ack  : mem_ack;
  assign beat_adv = (state == ST_STORE) && dst_ack;
  assign cap_vr   = (state == ST_FETCH) && !is_rst && vr_ack;
  assign cap_mem  = (state == ST_FETCH) &&  is_rst && mem_ack;

  vpx_beat #(.SECT(SECT), .ELEM_W(ELEM_W)) u_beat (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .load_addr(gr_addr_in), .load_elem(c_elem),
    .adv(beat_adv),
    .cap_mem(cap_mem), .mem_rdata(mem_rdata),
    .cap_vr(cap_vr), .vr_hi(vr_rd_hi), .vr_lo(vr_rd_lo),
    .addr_q(addr_q), .elem_q(elem_q), .data_q(data_q), .last_elem(last_elem)
  );

  assign mem_req   = ((state == ST_FETCH) && is_rst) || ((state == ST_STORE) && !is_rst);
  assign mem_we    = !is_rst;
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;

  assign vr_req   = ((state == ST_FETCH) && !is_rst) || ((state == ST_STORE) && is_rst);
  assign vr_we    = is_rst;
  assign vr_pair  = pair_q;
  assign vr_elem  = elem_q[EW-1:0];
  assign vr_wd_hi = data_q[DW-1:ELEM_W];
  assign vr_wd_lo = data_q[ELEM_W-1:0];

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_FIN);
  assign chg_pair = pair_q;
  assign chg_set  = done && moved_q && is_rst && !priv_q;
  assign chg_clr  = done && moved_q && (mode_q == MD_SAVE_CHG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      mode_q      <= MD_SAVE;
      priv_q      <= 1'b0;
      moved_q     <= 1'b0;
      pair_q      <= '0;
      spec_err    <= 1'b0;
      priv_err    <= 1'b0;
      cc          <= '0;
      gr_addr_out <= '0;
      gr_ctl_out  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            mode_q   <= xfer_mode_e'(mode);
            priv_q   <= priv;
            pair_q   <= c_pair;
            spec_err <= c_spec;
            priv_err <= c_priv;
            if (c_spec || c_priv) begin
              moved_q     <= 1'b0;
              cc          <= 2'd0;
              gr_addr_out <= gr_addr_in;
              gr_ctl_out  <= gr_ctl_in;
              state       <= ST_FIN;
            end else if (!c_take) begin
              moved_q     <= 1'b0;
              cc          <= cond_code(c_pair, 1'b0);
              gr_addr_out <= gr_addr_in + tail_bytes(c_elem, SECT);
              gr_ctl_out  <= next_ctl(c_pair);
              state       <= ST_FIN;
            end else begin
              moved_q <= 1'b1;
              state   <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (src_ack) state <= ST_STORE;
        end
        ST_STORE: begin
          if (dst_ack) begin
            if (last_elem) begin
              cc          <= cond_code(pair_q, 1'b1);
              gr_addr_out <= addr_q + 32'd8;
              gr_ctl_out  <= next_ctl(pair_q);
              state       <= ST_FIN;
            end else begin
              state <= ST_FETCH;
            end
          end
        end
        ST_FIN: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vpx_checker.sv
module vpx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        mem_req,
  input logic        vr_req,
  input logic        chg_set,
  input logic        chg_clr,
  input logic        spec_err,
  input logic        priv_err,
  input logic [1:0]  cc,
  input logic        beat_adv,
  input logic [31:0] addr_q,
  input logic        moved_q
);
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_err || priv_err) && busy |-> !mem_req && !vr_req); // R1

  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && vr_req)); // R5

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    beat_adv |=> addr_q == $past(addr_q) + 32'd8); // R5

  AST_CC_MOVED: assert property (@(posedge clk) disable iff (!rst_n)
    done && !spec_err && !priv_err |-> cc[1] == moved_q); // R7

  AST_CHG_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_set || chg_clr) |-> done && moved_q && !(chg_set && chg_clr)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy ##1 !done); // R11

  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || vr_req) |-> busy && !done); // R11

  AST_ONE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(spec_err && priv_err)); // R3
endmodule

bind vpair_xfer_seq vpx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .mem_req(mem_req), .vr_req(vr_req), .chg_set(chg_set), .chg_clr(chg_clr),
  .spec_err(spec_err), .priv_err(priv_err), .cc(cc),
  .beat_adv(beat_adv), .addr_q(addr_q), .moved_q(moved_q)
);

// File: tb/vpair_xfer_seq_tb.sv
module vpair_xfer_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SECT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        start = 0, priv = 0;
  logic [1:0]  mode = 0;
  logic [3:0]  base_gr = 0;
  logic [31:0] gr_addr_in = 0, gr_ctl_in = 0;
  logic [7:0]  pair_inuse = 0, pair_changed = 0;
  logic        mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata = 0;
  logic        vr_req, vr_we, vr_ack = 0;
  logic [2:0]  vr_pair, chg_pair;
  logic [3:0]  vr_elem;
  logic [31:0] vr_wd_hi, vr_wd_lo, vr_rd_hi = 0, vr_rd_lo = 0;
  logic        chg_set, chg_clr, busy, done, spec_err, priv_err;
  logic [1:0]  cc;
  logic [31:0] gr_addr_out, gr_ctl_out;

  vpair_xfer_seq #(.SECT(SECT), .ELEM_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .priv(priv), .base_gr(base_gr),
    .gr_addr_in(gr_addr_in), .gr_ctl_in(gr_ctl_in),
    .pair_inuse(pair_inuse), .pair_changed(pair_changed),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .vr_req(vr_req), .vr_we(vr_we), .vr_pair(vr_pair), .vr_elem(vr_elem),
    .vr_wd_hi(vr_wd_hi), .vr_wd_lo(vr_wd_lo), .vr_rd_hi(vr_rd_hi), .vr_rd_lo(vr_rd_lo),
    .vr_ack(vr_ack), .chg_set(chg_set), .chg_clr(chg_clr), .chg_pair(chg_pair),
    .busy(busy), .done(done), .spec_err(spec_err), .priv_err(priv_err), .cc(cc),
    .gr_addr_out(gr_addr_out), .gr_ctl_out(gr_ctl_out)
  );

  // external memory and register file models
  logic [63:0] mem [0:127];
  logic [63:0] vrf [0:7][0:15];
  int mem_beats = 0, vr_beats = 0;

  always @(posedge clk) begin
    mem_ack <= mem_req && !mem_ack;
    if (mem_req && !mem_ack) begin
      if (mem_we) mem[mem_addr[9:3]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[9:3]];
      mem_beats <= mem_beats + 1;
    end
    vr_ack <= vr_req && !vr_ack;
    if (vr_req && !vr_ack) begin
      if (vr_we) vrf[vr_pair][vr_elem] <= {vr_wd_hi, vr_wd_lo};
      vr_rd_hi <= vrf[vr_pair][vr_elem][63:32];
      vr_rd_lo <= vrf[vr_pair][vr_elem][31:0];
      vr_beats <= vr_beats + 1;
    end
  end

  int checks = 0, fails = 0, cycles = 0;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired act=%0d exp=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // results captured in the done cycle
  logic [1:0]  r_cc;
  logic [31:0] r_addr, r_ctl;
  logic        r_spec, r_priv, r_set, r_clr, r_busy_ok, r_after;
  logic [2:0]  r_cpair;
  int          r_mem, r_vr;

  task automatic run_op(input logic [1:0] md, input logic pv, input logic [3:0] bg,
                        input logic [31:0] a, input logic [31:0] c);
    int m0, v0, w;
    @(negedge clk);
    mode = md; priv = pv; base_gr = bg; gr_addr_in = a; gr_ctl_in = c; start = 1'b1;
    m0 = mem_beats; v0 = vr_beats;
    @(negedge clk);
    start = 1'b0;
    w = 0; r_busy_ok = 1'b1;
    while (!done && w < 500) begin
      if (!busy) r_busy_ok = 1'b0;
      @(negedge clk);
      w++;
    end
    chk("R11 done reached", {63'h0, done}, 64'h1);
    chk("R11 busy with done", {63'h0, busy & r_busy_ok}, 64'h1);
    r_cc = cc; r_addr = gr_addr_out; r_ctl = gr_ctl_out; r_spec = spec_err; r_priv = priv_err;
    r_set = chg_set; r_clr = chg_clr; r_cpair = chg_pair;
    r_mem = mem_beats - m0; r_vr = vr_beats - v0;
    @(negedge clk);
    r_after = done | busy;
    chk("R11 idle after done", {63'h0, r_after}, 64'h0);
  endtask

  function automatic logic [63:0] vpat(input int p, input int e);
    return {8'h10 + 8'(p), 24'(e), 8'h20 + 8'(p), 24'(e)};
  endfunction

  task automatic init_models();
    for (int i = 0; i < 128; i++) mem[i] = {32'hA000_0000 + 32'(i), 32'h5000_0000 + 32'(i)};
    for (int p = 0; p < 8; p++)
      for (int e = 0; e < 16; e++) vrf[p][e] = vpat(p, e);
  endtask

  task automatic t_reset();
    chk("R11 reset busy", {63'h0, busy}, 64'h0);
    chk("R11 reset done", {63'h0, done}, 64'h0);
    chk("R5 reset no request", {62'h0, mem_req, vr_req}, 64'h0);
  endtask

  // R4 R5 R7 R8 R10: full save of pair 2 (index 1)
  task automatic t_save_full();
    logic ok;
    pair_inuse = 8'b0000_0010; pair_changed = 8'h00;
    run_op(2'b00, 1'b1, 4'd2, 32'h40, 32'h0000_0002);
    chk("R5 beats full save", 64'(r_mem), 64'd16);
    ok = 1'b1;
    for (int e = 0; e < 16; e++) if (mem[8 + e] !== vpat(1, e)) ok = 1'b0;
    chk("R4 save packing even-high", {63'h0, ok}, 64'h1);
    chk("R7 cc pair2 moved", 64'(r_cc), 64'd3);
    chk("R8 addr after save", 64'(r_addr), 64'hC0);
    chk("R8 ctl after save", 64'(r_ctl), 64'd4);
    chk("R9 no change pulses on save", {62'h0, r_set, r_clr}, 64'h0);
  endtask

  // R5 R7 R8: resume pair 14 at element 5
  task automatic t_save_resume();
    logic ok;
    pair_inuse = 8'b1000_0000;
    run_op(2'b00, 1'b0, 4'd4, 32'h128, {16'd5, 16'd14});
    chk("R5 beats resume", 64'(r_mem), 64'd11);
    ok = 1'b1;
    for (int e = 5; e < 16; e++) if (mem[32 + e] !== vpat(7, e)) ok = 1'b0;
    chk("R5 resume contents", {63'h0, ok}, 64'h1);
    chk("R5 element before start untouched", mem[36], {32'hA000_0024, 32'h5000_0024});
    chk("R7 cc pair14 moved", 64'(r_cc), 64'd2);
    chk("R8 addr after resume", 64'(r_addr), 64'h180);
    chk("R8 ctl after pair14", 64'(r_ctl), 64'd16);
  endtask

  // R4 R9 R10: restore pair 4, problem then supervisor state
  task automatic t_restore();
    logic ok;
    pair_inuse = 8'b0000_0100;
    run_op(2'b10, 1'b0, 4'd0, 32'h200, 32'h0000_0004);
    ok = 1'b1;
    for (int e = 0; e < 16; e++)
      if (vrf[2][e] !== {32'hA000_0040 + 32'(e), 32'h5000_0040 + 32'(e)}) ok = 1'b0;
    chk("R4 restore unpacking", {63'h0, ok}, 64'h1);
    chk("R5 restore beats", 64'(r_mem), 64'd16);
    chk("R9 restore problem sets changed", {61'h0, r_set, r_cpair}, {61'h0, 1'b1, 3'd2});
    chk("R7 cc restore", 64'(r_cc), 64'd3);
    run_op(2'b10, 1'b1, 4'd0, 32'h200, 32'h0000_0004);
    chk("R9 restore supervisor no set", {62'h0, r_set, r_clr}, 64'h0);
  endtask

  // R6 R7 R10: skipped pairs
  task automatic t_skip();
    pair_inuse = 8'b0111_0111; pair_changed = 8'hFF;
    run_op(2'b00, 1'b1, 4'd6, 32'h318, {16'd3, 16'd6});
    chk("R6 skip no beats", 64'(r_mem + r_vr), 64'd0);
    chk("R6 skip address", 64'(r_addr), 64'h380);
    chk("R7 cc pair6 skipped", 64'(r_cc), 64'd1);
    chk("R8 ctl after skip", 64'(r_ctl), 64'd8);
    pair_inuse = 8'b0111_1111;
    run_op(2'b10, 1'b0, 4'd6, 32'h300, {16'd0, 16'd14});
    chk("R7 cc pair14 skipped", 64'(r_cc), 64'd0);
    chk("R9 skipped restore no set", {63'h0, r_set}, 64'h0);
    chk("R6 skip full pair", 64'(r_addr), 64'h380);
  endtask

  // R9 R10: save-changed
  task automatic t_save_changed();
    pair_inuse = 8'hFF; pair_changed = 8'b0000_1000;
    run_op(2'b01, 1'b1, 4'd8, 32'h000, 32'h0000_0006);
    chk("R10 save-changed moves changed pair", 64'(r_mem), 64'd16);
    chk("R9 clear changed", {61'h0, r_clr, r_cpair}, {61'h0, 1'b1, 3'd3});
    run_op(2'b01, 1'b1, 4'd8, 32'h000, 32'h0000_0008);
    chk("R10 save-changed skips unchanged in-use pair", 64'(r_mem + r_vr), 64'd0);
    chk("R9 no clear on skip", {63'h0, r_clr}, 64'h0);
  endtask

  // R3: privilege error beats specification error
  task automatic t_priv();
    pair_changed = 8'hFF;
    run_op(2'b01, 1'b0, 4'd2, 32'h40, 32'h0000_0002);
    chk("R3 priv flags", {62'h0, r_priv, r_spec}, 64'b10);
    chk("R3 priv no beats", 64'(r_mem + r_vr), 64'd0);
    chk("R3 priv regs kept", {r_addr, r_ctl}, {32'h40, 32'h2});
    run_op(2'b01, 1'b0, 4'd2, 32'h44, 32'h0000_0002);
    chk("R3 priv over misalign", {62'h0, r_priv, r_spec}, 64'b10);
  endtask

  task automatic spec_case(input string tag, input logic [1:0] md, input logic [3:0] bg,
                           input logic [31:0] a, input logic [31:0] c);
    run_op(md, 1'b1, bg, a, c);
    chk({tag, " spec flag"}, {62'h0, r_spec, r_priv}, 64'b10);
    chk({tag, " no beats"}, 64'(r_mem + r_vr), 64'd0);
    chk({tag, " regs kept"}, {r_addr, r_ctl}, {a, c});
    chk({tag, " cc"}, 64'(r_cc), 64'd0);
  endtask

  task automatic t_spec();
    pair_inuse = 8'hFF;
    spec_case("R1 elem16", 2'b00, 4'd2, 32'h80, {16'd16, 16'd0});
    spec_case("R1 odd pair", 2'b00, 4'd2, 32'h40, {16'd0, 16'd3});
    spec_case("R1 pair16", 2'b00, 4'd2, 32'h40, {16'd0, 16'd16});
    spec_case("R1 odd base", 2'b10, 4'd3, 32'h40, {16'd0, 16'd2});
    spec_case("R1 reserved mode", 2'b11, 4'd2, 32'h40, {16'd0, 16'd2});
    spec_case("R2 misaligned", 2'b00, 4'd2, 32'h60, {16'd0, 16'd2});
    spec_case("R2 misaligned resume", 2'b00, 4'd2, 32'h48, {16'd2, 16'd2});
    // aligned with offset: 0x50 - 8*2 = 0x40 is on a 64-byte boundary
    run_op(2'b00, 1'b1, 4'd2, 32'h50, {16'd2, 16'd2});
    chk("R2 offset start accepted", {62'h0, r_spec, r_priv}, 64'h0);
    chk("R2 offset start beats", 64'(r_mem), 64'd14);
  endtask

  initial begin
    init_models();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_save_full();
    t_save_resume();
    t_restore();
    t_skip();
    t_save_changed();
    t_priv();
    t_spec();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule